// File: doc/BRIEF.md
# ALU Operand Read-Port Checker

This block checks whether one ALU instruction group can fetch all of its register operands without oversubscribing the register file. A group is made of up to five scalar slots. The four vector slots come first and the transcendental slot comes last. The block receives one slot per valid beat. Each beat carries up to three source selects with their component elements, the number of sources in use, a swizzle code that places each source in one of three fetch cycles, a flag that marks the transcendental slot, and a flag that marks the last slot of the group.

Operand fetch is modelled as a 3-by-4 grid. The rows are fetch cycles 0 to 2 and the columns are the component banks x, y, z and w. Each cell can hold one register index per group. For each beat the block claims cells, counts the distinct GPRs and constant components the group uses, and applies the timing limits of the transcendental slot. On the beat that closes the group it registers a pass flag and a one-hot violation code, then clears all of its state for the next group. Nothing is executed or decoded beyond the operand fields.

Top module: `rdport_check`

## Requirements
- R1: The 3-bit swizzle code sets the fetch cycles of (src0, src1, src2) as follows: 0→(0,1,2), 1→(0,2,1), 2→(1,2,0), 3→(1,0,2), 4→(2,0,1), 5→(2,1,0). Codes 6 and 7 behave like code 0.
- R2: Source selects 0–127 are GPRs. A GPR operand occupies the cell (its cycle, its element), with element 0..3 = x..w. If that cell already holds a different register in the same group, the result code is 5'b00001 (bank conflict). An operand that conflicts does not take the cell.
- R3: Any number of operands in the same or in later slots of the group may use a cell that already holds the same register without a conflict.
- R4: When src0 and src1 of a slot are the same GPR with the same element and both are in use, src1 takes no cell and its swizzle cycle is ignored.
- R5: The following selects never take a cell: constants (128–191), inline values (248–253), previous vector (254), previous scalar (255) and the unassigned values (192–247).
- R6: A group may use at most 3 distinct GPR indices, whatever the component. A fourth distinct index gives code 5'b00010.
- R7: A group may use at most 4 distinct constant components (select and element pair, selects 128–191). The transcendental slot may use at most 2 distinct such pairs. Exceeding either limit gives code 5'b00100.
- R8: In the transcendental slot, a GPR read that takes a cell, or a 254/255 operand, is illegal in cycle 0 when the slot has exactly one constant operand. When the slot has two or more constant operands, such a read is legal only in cycle 2. Breaking this rule gives code 5'b01000.
- R9: On the clock edge after a beat with the last flag, res_valid is 1 for exactly one cycle and res_pass equals (res_code == 0). At all other times res_valid, res_pass and res_code are 0.
- R10: When several violations occur, only the one of highest priority is reported, in this order: slot overrun, bank conflict, GPR count, constant count, transcendental cycle rule.
- R11: A beat that arrives after five beats without a last flag is an overrun. From then on, beats are ignored until a beat with the last flag closes the group with code 5'b10000. The next group starts clean.
- R12: Only sources src0..src(n-1) are examined, where n is slot_nsrc (0 to 3).
- R13: After a synchronous active-low reset, all outputs are 0 and no group is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_valid | input | 1 | A slot is presented on this beat |
| slot_last | input | 1 | This slot closes the group |
| slot_trans | input | 1 | This slot is the transcendental slot |
| slot_nsrc | input | 2 | Number of sources in use (0..3) |
| src_sel | input | 24 | Source selects, src0 in bits 7:0, src1 in 15:8, src2 in 23:16 |
| src_elem | input | 6 | Source elements, src0 in bits 1:0, src1 in 3:2, src2 in 5:4 |
| slot_swz | input | 3 | Swizzle code of the slot |
| res_valid | output | 1 | Result strobe for one cycle |
| res_pass | output | 1 | Group is legal |
| res_code | output | 5 | One-hot violation: bit0 bank, bit1 GPR count, bit2 constants, bit3 trans cycle, bit4 overrun |

## Verification
All three result outputs are registered once, so they are due one clock edge after the beat that carries the last flag, and they return to zero on the edge after that. The bench drives every beat at a falling edge and samples the outputs at the next falling edge. At that point the previous beat's verdict is settled, so each closing beat is compared there against a bench model, and every other beat is checked for a quiet result. Idle gaps between groups are checked the same way. This shows that the strobe lasts one cycle and that state does not carry into the next group.

// File: rtl/rdport_pkg.sv
// Shared widths, operand record and helper functions for the read-port checker.
// Assumes three sources per slot and four component banks.
package rdport_pkg;
    localparam int SEL_W  = 8;
    localparam int ELEM_W = 2;
    localparam int NSRC   = 3;
    localparam int NCYC   = 3;
    localparam int NBANK  = 4;
    localparam int REG_W  = 7;
    localparam int CODE_W = 5;
    localparam int NCELL  = NCYC * NBANK;
    localparam int CELL_W = $clog2(NCELL);
    localparam int KEY_W  = SEL_W + ELEM_W;

    // Decoded view of one source operand
    typedef struct packed {
        logic              port;   // takes a register-file cell
        logic              gpr;    // select names a GPR
        logic              konst;  // select names a cached constant
        logic              prev;   // previous vector/scalar result
        logic [1:0]        cyc;    // fetch cycle from the swizzle
        logic [REG_W-1:0]  rg;     // GPR index
        logic [ELEM_W-1:0] el;     // component element
        logic [SEL_W-1:0]  sel;    // raw select
    } opnd_t;

    // Swizzle code -> {cycle of src0, src1, src2}
    function automatic logic [5:0] swz_map(input logic [2:0] code);
        case (code)
            3'd1:    return {2'd0, 2'd2, 2'd1};
            3'd2:    return {2'd1, 2'd2, 2'd0};
            3'd3:    return {2'd1, 2'd0, 2'd2};
            3'd4:    return {2'd2, 2'd0, 2'd1};
            3'd5:    return {2'd2, 2'd1, 2'd0};
            default: return {2'd0, 2'd1, 2'd2};
        endcase
    endfunction

    // Flags {trans, konst, gpr, bank} plus overrun -> single highest-priority bit
    function automatic logic [CODE_W-1:0] pick_code(input logic ovr, input logic [3:0] f);
        if (ovr)  return 5'b10000;
        if (f[0]) return 5'b00001;
        if (f[1]) return 5'b00010;
        if (f[2]) return 5'b00100;
        if (f[3]) return 5'b01000;
        return 5'b00000;
    endfunction
endpackage

// File: rtl/rdport_decode.sv
// Splits one slot into three operand records: class, fetch cycle and the
// square exemption for src1. Purely combinational.
module rdport_decode
    import rdport_pkg::*;
(
    input  logic [NSRC*SEL_W-1:0]  sel_i,
    input  logic [NSRC*ELEM_W-1:0] elem_i,
    input  logic [1:0]             nsrc_i,
    input  logic [2:0]             swz_i,
    output opnd_t [NSRC-1:0]       op_o
);
    logic [5:0] map;
    logic       sq1;

    // Cycle map and square detection (src1 repeats a GPR src0)
    assign map = swz_map(swz_i);
    assign sq1 = (nsrc_i >= 2'd2) && !sel_i[SEL_W-1]
              && (sel_i[0 +: SEL_W] == sel_i[SEL_W +: SEL_W])
              && (elem_i[0 +: ELEM_W] == elem_i[ELEM_W +: ELEM_W]);

    for (genvar i = 0; i < NSRC; i++) begin : g_op
        logic [SEL_W-1:0]  s;
        logic [ELEM_W-1:0] e;
        logic              used, isg, skip;
        assign s    = sel_i[i*SEL_W +: SEL_W];
        assign e    = elem_i[i*ELEM_W +: ELEM_W];
        assign used = (nsrc_i > 2'(i));
        assign isg  = used && !s[SEL_W-1];
        assign skip = (i == 1) && sq1;
        // Pack the operand record
        assign op_o[i] = {isg && !skip, isg, used && (s[7:6] == 2'b10),
                          used && (s >= 8'd254), map[5-2*i -: 2],
                          s[REG_W-1:0], e, s};
    end
endmodule

// File: rtl/rdport_banks.sv
// Cycle-by-bank occupancy grid for one group. A cell holds one register;
// a second different register in the same cell is a conflict.
module rdport_banks
    import rdport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             upd_i,
    input  opnd_t [NSRC-1:0] op_i,
    output logic             conflict_o
);
    logic [NCELL-1:0] occ_q, occ_d;
    logic [REG_W-1:0] reg_q [NCELL];
    logic [REG_W-1:0] reg_d [NCELL];
    logic [CELL_W-1:0] idx;
    logic              unused_op;

    assign unused_op = ^op_i;

    // Claim cells in source order, flag a differing register
    always_comb begin
        occ_d      = occ_q;
        reg_d      = reg_q;
        conflict_o = 1'b0;
        idx        = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (op_i[i].port) begin
                idx = CELL_W'(op_i[i].cyc) * CELL_W'(NBANK) + CELL_W'(op_i[i].el);
                if (occ_d[idx] && (reg_d[idx] != op_i[i].rg)) begin
                    conflict_o = 1'b1;
                end else begin
                    occ_d[idx] = 1'b1;
                    reg_d[idx] = op_i[i].rg;
                end
            end
        end
    end

    // Hold grid across the group, empty it when the group closes
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            occ_q <= '0;
        end else if (upd_i) begin
            occ_q <= occ_d;
            reg_q <= reg_d;
        end
    end
endmodule

// File: rtl/rdport_count.sv
// Distinct-resource counters for one group: GPR indices and constant
// (select, element) pairs, each bounded by a parameter.
module rdport_count
    import rdport_pkg::*;
#(
    parameter int MAX_GPR   = 3,
    parameter int MAX_CONST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             upd_i,
    input  opnd_t [NSRC-1:0] op_i,
    output logic             gpr_over_o,
    output logic             const_over_o
);
    localparam int GCW = $clog2(MAX_GPR + 1);
    localparam int KCW = $clog2(MAX_CONST + 1);

    logic [REG_W-1:0] g_q [MAX_GPR];
    logic [REG_W-1:0] g_d [MAX_GPR];
    logic [KEY_W-1:0] k_q [MAX_CONST];
    logic [KEY_W-1:0] k_d [MAX_CONST];
    logic [GCW-1:0]   gn_q, gn_d;
    logic [KCW-1:0]   kn_q, kn_d;
    logic             ghit, khit, unused_op;

    assign unused_op = ^op_i;

    // Insert new GPR indices, flag one past the limit
    always_comb begin
        g_d = g_q; gn_d = gn_q; gpr_over_o = 1'b0; ghit = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (op_i[i].gpr) begin
                ghit = 1'b0;
                for (int j = 0; j < MAX_GPR; j++)
                    if ((GCW'(j) < gn_d) && (g_d[j] == op_i[i].rg)) ghit = 1'b1;
                if (!ghit) begin
                    if (gn_d == GCW'(MAX_GPR)) gpr_over_o = 1'b1;
                    else begin g_d[gn_d] = op_i[i].rg; gn_d = gn_d + 1'b1; end
                end
            end
        end
    end

    // Insert new constant pairs, flag one past the limit
    always_comb begin
        k_d = k_q; kn_d = kn_q; const_over_o = 1'b0; khit = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (op_i[i].konst) begin
                khit = 1'b0;
                for (int j = 0; j < MAX_CONST; j++)
                    if ((KCW'(j) < kn_d) && (k_d[j] == {op_i[i].sel, op_i[i].el})) khit = 1'b1;
                if (!khit) begin
                    if (kn_d == KCW'(MAX_CONST)) const_over_o = 1'b1;
                    else begin k_d[kn_d] = {op_i[i].sel, op_i[i].el}; kn_d = kn_d + 1'b1; end
                end
            end
        end
    end

    // Keep lists for the group, reset them at group close
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            gn_q <= '0;
            kn_q <= '0;
        end else if (upd_i) begin
            gn_q <= gn_d; g_q <= g_d;
            kn_q <= kn_d; k_q <= k_d;
        end
    end
endmodule

// File: rtl/rdport_trans.sv
// Transcendental-slot rules: at most two distinct constants, and the fetch
// cycle limits that depend on how many constant operands the slot has.
module rdport_trans
    import rdport_pkg::*;
(
    input  logic             trans_i,
    input  opnd_t [NSRC-1:0] op_i,
    output logic             kover_o,
    output logic             cyc_viol_o
);
    logic [1:0]       nk;
    logic [KEY_W-1:0] key [NSRC];
    logic             unused_op;

    assign unused_op = ^op_i;

    // Count constants, test three-distinct case and cycle limits
    always_comb begin
        nk = 2'd0;
        for (int i = 0; i < NSRC; i++) begin
            nk     = nk + {1'b0, op_i[i].konst};
            key[i] = {op_i[i].sel, op_i[i].el};
        end
        kover_o = trans_i && (nk == 2'd3) && (key[0] != key[1])
               && (key[0] != key[2]) && (key[1] != key[2]);
        cyc_viol_o = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (trans_i && (op_i[i].port || op_i[i].prev)) begin
                if ((nk == 2'd1) && (op_i[i].cyc == 2'd0)) cyc_viol_o = 1'b1;
                if ((nk >= 2'd2) && (op_i[i].cyc != 2'd2)) cyc_viol_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rdport_check.sv
// Top: accepts slots of a group beat by beat, accumulates violations and
// registers a one-hot verdict on the edge after the closing beat.
// Assumes the source sends slots in x, y, z, w, trans order.
module rdport_check
    import rdport_pkg::*;
#(
    parameter int MAX_SLOTS = 5,
    parameter int MAX_GPR   = 3,
    parameter int MAX_CONST = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    slot_valid,
    input  logic                    slot_last,
    input  logic                    slot_trans,
    input  logic [1:0]              slot_nsrc,
    input  logic [NSRC*SEL_W-1:0]   src_sel,
    input  logic [NSRC*ELEM_W-1:0]  src_elem,
    input  logic [2:0]              slot_swz,
    output logic                    res_valid,
    output logic                    res_pass,
    output logic [CODE_W-1:0]       res_code
);
    localparam int CNT_W = $clog2(MAX_SLOTS + 1);

    opnd_t [NSRC-1:0] op;
    logic [CNT_W-1:0] cnt_q;
    logic             ovr_q, overrun, live, close;
    logic             conflict, gpr_over, const_over, t_kover, t_cyc;
    logic [3:0]       acc_q, flags;
    logic [CODE_W-1:0] code_nxt;

    rdport_decode u_dec (
        .sel_i(src_sel), .elem_i(src_elem), .nsrc_i(slot_nsrc),
        .swz_i(slot_swz), .op_o(op)
    );

    rdport_banks u_banks (
        .clk(clk), .rst_n(rst_n), .clear_i(close), .upd_i(live),
        .op_i(op), .conflict_o(conflict)
    );

    rdport_count #(.MAX_GPR(MAX_GPR), .MAX_CONST(MAX_CONST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear_i(close), .upd_i(live),
        .op_i(op), .gpr_over_o(gpr_over), .const_over_o(const_over)
    );

    rdport_trans u_trans (
        .trans_i(slot_trans), .op_i(op), .kover_o(t_kover), .cyc_viol_o(t_cyc)
    );

    // Beat classification and this beat's violations
    assign overrun  = slot_valid && (ovr_q || (cnt_q == CNT_W'(MAX_SLOTS)));
    assign live     = slot_valid && !overrun;
    assign close    = slot_valid && slot_last;
    assign flags    = live ? {t_cyc, const_over || t_kover, gpr_over, conflict} : 4'b0;
    assign code_nxt = pick_code(ovr_q || overrun, acc_q | flags);

    // Group sequencing: slot count, overrun latch, violation accumulator
    always_ff @(posedge clk) begin
        if (!rst_n || close) begin
            cnt_q <= '0;
            ovr_q <= 1'b0;
            acc_q <= '0;
        end else if (slot_valid) begin
            ovr_q <= ovr_q || overrun;
            acc_q <= acc_q | flags;
            if (!overrun) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered verdict, one cycle wide
    always_ff @(posedge clk) begin
        if (!rst_n || !close) begin
            res_valid <= 1'b0;
            res_pass  <= 1'b0;
            res_code  <= '0;
        end else begin
            res_valid <= 1'b1;
            res_pass  <= (code_nxt == '0);
            res_code  <= code_nxt;
        end
    end
endmodule

// File: rtl/rdport_check_sva.sv
// Checker for the port-level timing and coding of the verdict; keeps its
// own beat count to predict overruns.
module rdport_check_sva #(
    parameter int MAX_SLOTS = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       slot_valid,
    input logic       slot_last,
    input logic       res_valid,
    input logic       res_pass,
    input logic [4:0] res_code
);
    localparam int BW = $clog2(MAX_SLOTS + 2);
    logic [BW-1:0] beats_q;

    // Independent count of beats in the open group
    always_ff @(posedge clk) begin
        if (!rst_n || (slot_valid && slot_last)) beats_q <= '0;
        else if (slot_valid && (beats_q <= BW'(MAX_SLOTS))) beats_q <= beats_q + 1'b1;
    end

    a_r9_valid_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(slot_valid && slot_last));
    a_r9_last_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_last) |=> res_valid);
    a_r9_pass_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_pass == (res_code == 5'b0)));
    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_pass && (res_code == 5'b0)));
    a_r10_single_code: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot0(res_code));
    a_r11_overrun_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_last && (beats_q >= BW'(MAX_SLOTS))) |=> res_code[4]);
endmodule

bind rdport_check rdport_check_sva #(.MAX_SLOTS(MAX_SLOTS)) u_sva (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_last(slot_last),
    .res_valid(res_valid), .res_pass(res_pass), .res_code(res_code)
);

// File: tb/rdport_check_test.sv
`timescale 1ns/1ps
module rdport_check_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_valid = 1'b0, slot_last = 1'b0, slot_trans = 1'b0;
    logic [1:0]  slot_nsrc = '0;
    logic [23:0] src_sel = '0;
    logic [5:0]  src_elem = '0;
    logic [2:0]  slot_swz = '0;
    logic        res_valid, res_pass;
    logic [4:0]  res_code;

    int nchk = 0, nbad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rdport_check uut (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_last(slot_last),
        .slot_trans(slot_trans), .slot_nsrc(slot_nsrc), .src_sel(src_sel),
        .src_elem(src_elem), .slot_swz(slot_swz), .res_valid(res_valid),
        .res_pass(res_pass), .res_code(res_code)
    );

    // ---------------- reference model ----------------
    bit  m_occ[12];
    int  m_reg[12];
    int  m_g[$];
    int  m_k[$];
    int  m_cnt = 0;
    bit  m_ovr = 0;
    bit [3:0] m_acc = 0;

    function automatic int cyc_of(int sw, int i);
        int m[3];
        case (sw)
            1: m = '{0, 2, 1};
            2: m = '{1, 2, 0};
            3: m = '{1, 0, 2};
            4: m = '{2, 0, 1};
            5: m = '{2, 1, 0};
            default: m = '{0, 1, 2};
        endcase
        return m[i];
    endfunction

    function automatic bit [4:0] prio(bit ovr, bit [3:0] f);
        if (ovr) return 5'b10000;
        for (int b = 0; b < 4; b++) if (f[b]) return 5'b00001 << b;
        return 5'b0;
    endfunction

    task automatic model(input int s[3], input int e[3], input int n, input int sw,
                         input bit tr, input bit last, output bit [4:0] code);
        bit bank = 0, gov = 0, kov = 0, tcy = 0, sq;
        int nk = 0;
        int tk[$];
        if (m_ovr || m_cnt == 5) m_ovr = 1;
        else begin
            m_cnt++;
            sq = (n >= 2) && s[0] < 128 && s[0] == s[1] && e[0] == e[1];
            for (int i = 0; i < n; i++) begin
                bit port = (s[i] < 128) && !(i == 1 && sq);
                if (port) begin
                    int ix = cyc_of(sw, i) * 4 + e[i];
                    if (m_occ[ix] && m_reg[ix] != s[i]) bank = 1;
                    else begin m_occ[ix] = 1; m_reg[ix] = s[i]; end
                end
                if (s[i] < 128) begin
                    int f[$] = m_g.find_index(x) with (x == s[i]);
                    if (f.size() == 0) begin
                        if (m_g.size() == 3) gov = 1; else m_g.push_back(s[i]);
                    end
                end
                if (s[i] >= 128 && s[i] < 192) begin
                    int key = s[i] * 4 + e[i];
                    int f[$] = m_k.find_index(x) with (x == key);
                    int g[$] = tk.find_index(x) with (x == key);
                    nk++;
                    if (g.size() == 0) tk.push_back(key);
                    if (f.size() == 0) begin
                        if (m_k.size() == 4) kov = 1; else m_k.push_back(key);
                    end
                end
            end
            if (tr) begin
                if (tk.size() > 2) kov = 1;
                for (int i = 0; i < n; i++) begin
                    bit rd = ((s[i] < 128) && !(i == 1 && sq)) || s[i] >= 254;
                    int c = cyc_of(sw, i);
                    if (rd && ((nk == 1 && c == 0) || (nk >= 2 && c != 2))) tcy = 1;
                end
            end
            m_acc |= {tcy, kov, gov, bank};
        end
        code = prio(m_ovr, m_acc);
        if (last) begin
            for (int i = 0; i < 12; i++) m_occ[i] = 0;
            m_g.delete(); m_k.delete(); m_cnt = 0; m_ovr = 0; m_acc = 0;
        end
    endtask

    // ---------------- check helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one slot at a falling edge, check at the next falling edge
    task automatic beat(input int s0, e0, s1, e1, s2, e2, input int n, input int sw,
                        input bit tr, input bit last, input string tag);
        int s[3] = '{s0, s1, s2};
        int e[3] = '{e0, e1, e2};
        bit [4:0] exp;
        slot_valid = 1; slot_last = last; slot_trans = tr;
        slot_nsrc  = n[1:0]; slot_swz = sw[2:0];
        src_sel  = {s2[7:0], s1[7:0], s0[7:0]};
        src_elem = {e2[1:0], e1[1:0], e0[1:0]};
        model(s, e, n, sw, tr, last, exp);
        @(negedge clk);
        slot_valid = 0; slot_last = 0; slot_trans = 0;
        if (last) begin
            chk(res_valid == 1'b1, {tag, " valid R9"}, res_valid, 1);
            chk(res_code == exp, {tag, " code"}, res_code, exp);
            chk(res_pass == (exp == 0), {tag, " pass R9"}, res_pass, exp == 0);
        end else begin
            chk(res_valid == 1'b0, {tag, " no early result R9"}, res_valid, 0);
        end
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        chk(res_valid == 0 && res_code == 0 && res_pass == 0, {tag, " idle R9"}, res_code, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nbad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk(res_valid == 0 && res_pass == 0 && res_code == 0, "R13 reset outputs", res_code, 0);
        rst_n = 1;
        @(negedge clk);

        // R1 R3: shared reads across slots with three swizzles
        beat(1,0, 2,0, 0,0, 2, 0, 0, 0, "R1 x");
        beat(3,0, 1,1, 0,0, 2, 4, 0, 0, "R1 y");
        beat(2,0, 1,1, 0,0, 2, 3, 0, 1, "R3 shared reads");
        // R2: bank conflict in cycle 0 bank x
        beat(1,0, 2,0, 0,0, 2, 0, 0, 0, "R2 x");
        beat(3,0, 0,0, 0,0, 1, 0, 0, 1, "R2 bank conflict");
        // R4: square frees src1's cell
        beat(1,0, 1,0, 0,0, 2, 3, 0, 0, "R4 x");
        beat(2,0, 0,0, 0,0, 1, 0, 0, 1, "R4 square");
        // R5: constants, inline, previous results take no cell
        beat(1,0, 0,0, 0,0, 1, 0, 0, 0, "R5 x");
        beat(128,0, 254,0, 249,0, 3, 0, 0, 0, "R5 y");
        beat(200,0, 255,0, 0,0, 2, 0, 0, 0, "R5 z");
        beat(2,0, 0,0, 0,0, 1, 3, 0, 1, "R5 no port");
        // R6: fourth distinct GPR
        beat(1,0, 2,1, 3,2, 3, 0, 0, 0, "R6 x");
        beat(4,3, 0,0, 0,0, 1, 0, 0, 1, "R6 gpr limit");
        // R7: fifth distinct constant pair
        beat(128,0, 128,1, 129,0, 3, 0, 0, 0, "R7 x");
        beat(129,1, 130,0, 0,0, 2, 0, 0, 1, "R7 const limit");
        // R7: trans with three distinct constants
        beat(128,0, 129,0, 130,0, 3, 0, 1, 1, "R7 trans consts");
        // R8: one constant, GPR in cycle 0 fails; cycle 2 passes
        beat(1,0, 128,0, 0,0, 2, 0, 1, 1, "R8 one const c0");
        beat(1,0, 128,0, 0,0, 2, 4, 1, 1, "R8 one const c2");
        // R8: two constants, GPR only in cycle 2; PV in cycle 0 fails
        beat(128,0, 129,0, 1,1, 3, 0, 1, 1, "R8 two const c2");
        beat(128,0, 129,0, 1,1, 3, 1, 1, 1, "R8 two const c1");
        beat(128,0, 129,0, 254,0, 3, 5, 1, 1, "R8 pv c0");
        // R10: bank conflict outranks GPR count
        beat(1,0, 2,1, 3,2, 3, 0, 0, 0, "R10 x");
        beat(4,0, 0,0, 0,0, 1, 0, 0, 1, "R10 priority");
        // R12: unused src1 ignored
        beat(1,0, 2,0, 0,0, 1, 0, 0, 0, "R12 x");
        beat(3,0, 0,0, 0,0, 1, 2, 0, 1, "R12 nsrc");
        idle("R9 gap");
        // R11 R10: overrun with an earlier conflict, then clean resync
        beat(1,0, 0,0, 0,0, 1, 0, 0, 0, "R11 s1");
        beat(2,0, 0,0, 0,0, 1, 0, 0, 0, "R11 s2");
        for (int i = 0; i < 4; i++) beat(0,0, 0,0, 0,0, 0, 0, 0, 0, "R11 fill");
        beat(5,0, 0,0, 0,0, 1, 0, 0, 1, "R11 overrun");
        beat(1,0, 2,0, 0,0, 2, 0, 0, 1, "R11 resync");
        idle("R9 gap2");

        // Random groups, fixed seed
        void'($urandom(32'd1234));
        for (int g = 0; g < 400; g++) begin
            int ns = 1 + ($urandom % 5);
            if ($urandom % 10 == 0) ns = 6 + ($urandom % 2);
            for (int k = 0; k < ns; k++) begin
                int ss[3];
                int ee[3];
                for (int j = 0; j < 3; j++) begin
                    int p = $urandom % 10;
                    ss[j] = (p < 5) ? int'($urandom % 4) :
                            (p == 5) ? 128 : (p == 6) ? 129 : (p == 7) ? 160 :
                            (p == 8) ? 248 : 254 + int'($urandom % 2);
                    ee[j] = $urandom % 4;
                end
                beat(ss[0], ee[0], ss[1], ee[1], ss[2], ee[2], $urandom % 4, $urandom % 8,
                     (k == 4) || ($urandom % 8 == 0), k == ns - 1, "R1 R8 random");
            end
            if ($urandom % 4 == 0) idle("R9 random gap");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule